// File: doc/BRIEF.md
# Compare-Match Tracking Timer

This block takes the 16 MHz system clock and derives three periodic enables from one free-running prescaler: a 125 kHz strobe for quadrature decoding, a strobe of about 15.6 kHz for the motor current-limit logic, and a tick of about 3906 Hz. Each enable is a pulse that lasts one system-clock cycle. None of them is a separate clock. The tick advances a 14-bit up counter. A comparator watches that counter against a compare value that firmware writes. When a tick brings the count onto the compare value, a sticky match flag is set and an interrupt is raised unless it is masked.

Firmware reaches the block through single-cycle write strobes and a combinational read port. There are four register slots, selected by a 2-bit address:
- Slot 0 is the counter. A write loads it and a read returns it.
- Slot 1 is the compare value.
- Slot 2 holds the interrupt mask in bit 0. A read of slot 2 returns the mask in bit 0 and the flag in bit 1.
- Slot 3 is a command slot. Writing bit 0 clears the counter, and writing bit 1 acknowledges the flag.

The data width equals the counter width.

Top module: `track_timer`

## Requirements
- R1: After reset the counter, the compare value, the mask and the match flag are all zero, and reads of slots 0, 1 and 2 return zero.
- R2: `quad_en` pulses for one cycle every 2^QUAD_LOG2 cycles (default 128, 125 kHz). The first pulse comes on cycle 2^QUAD_LOG2-1 after reset is released.
- R3: `amp_en` pulses for one cycle every 2^AMP_LOG2 cycles (default 1024, about 15.6 kHz), with the same phase rule as R2.
- R4: `tick_en` pulses for one cycle every 2^TICK_LOG2 cycles (default 4096, about 3906 Hz), with the same phase rule as R2. The counter increments on the clock edge at which `tick_en` is high.
- R5: A counter at its maximum value (0x3FFF by default) wraps to zero on the next tick.
- R6: A write to slot 0 loads the written value into the counter. It takes priority over a tick in the same cycle.
- R7: A write to slot 3 with bit 0 set clears the counter. It takes priority over a tick in the same cycle.
- R8: A write to slot 1 sets the compare value and leaves the counter unchanged.
- R9: The match flag sets on the edge at which a tick steps the counter onto the compare value. A load that makes the count equal to the compare value does not set it.
- R10: The flag stays set until a write to slot 3 with bit 1 set clears it. If a new match occurs in the same cycle as that write, the flag remains set.
- R11: `irq` is high exactly when the flag is set and the mask (slot 2, bit 0) is clear. Masking does not discard a pending match.
- R12: Reads return the counter from slot 0, the compare value from slot 1, and {flag, mask} in bits [1:0] of slot 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register slot select for writes and reads |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `addr` |
| count | output | CNT_W | Current counter value |
| quad_en | output | 1 | Quadrature-decode rate enable |
| amp_en | output | 1 | Current-limit rate enable |
| tick_en | output | 1 | Counter advance enable |
| irq | output | 1 | Match interrupt, after the mask |

## Verification
The bench runs the block with a 4-bit counter and a divide-by-8 tick. This lets it step through every compare value and several full wraps.

It also places load, clear and flag-acknowledge writes exactly on tick edges:
- If tick won over a load or clear, the counter would read one more than the written value, or 1 instead of 0.
- If the acknowledge won over a simultaneous match, the match would be lost.
- If the comparator fired on loads, a load onto the compare value would raise a false interrupt.

Masking is checked to hide the match without clearing it. A per-cycle arithmetic model of the enable phases and the counter catches off-by-one dividers and a wrap that saturates or skips.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SLOT_COUNT = 2'd0,
        SLOT_CMP   = 2'd1,
        SLOT_CTRL  = 2'd2,
        SLOT_CMD   = 2'd3
    } slot_e;

    localparam int CMD_CLR_BIT = 0;
    localparam int CMD_ACK_BIT = 1;
    localparam int CTRL_MASK_BIT = 0;

    // Decoded write actions for one cycle.
    typedef struct packed {
        logic load;
        logic clear;
        logic cmp_wr;
        logic mask_wr;
        logic ack;
    } wr_act_t;

    function automatic wr_act_t decode_wr(input logic en, input slot_e sel,
                                          input logic clr_b, input logic ack_b);
        wr_act_t a;
        a.load    = en && (sel == SLOT_COUNT);
        a.cmp_wr  = en && (sel == SLOT_CMP);
        a.mask_wr = en && (sel == SLOT_CTRL);
        a.clear   = en && (sel == SLOT_CMD) && clr_b;
        a.ack     = en && (sel == SLOT_CMD) && ack_b;
        return a;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int TICK_LOG2 = 12,
    parameter int AMP_LOG2  = 10,
    parameter int QUAD_LOG2 = 7
) (
    input  logic clk,
    input  logic rst,
    output logic quad_en,
    output logic amp_en,
    output logic tick_en
);
    localparam int TW = TICK_LOG2;
    localparam logic [TW-1:0] M_QUAD = TW'((64'd1 << QUAD_LOG2) - 64'd1);
    localparam logic [TW-1:0] M_AMP  = TW'((64'd1 << AMP_LOG2) - 64'd1);
    localparam logic [TW-1:0] M_TICK = TW'((64'd1 << TICK_LOG2) - 64'd1);

    logic [TW-1:0] phase;
    logic [2:0]    taps;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    // One tap per derived rate: fires when its low phase bits are all ones.
    for (genvar g = 0; g < 3; g++) begin : g_tap
        localparam logic [TW-1:0] M = (g == 0) ? M_QUAD : (g == 1) ? M_AMP : M_TICK;
        assign taps[g] = ((phase & M) == M);
    end

    assign quad_en = taps[0];
    assign amp_en  = taps[1];
    assign tick_en = taps[2];

    assert_quad_single_R2: assert property (@(posedge clk) disable iff (rst)
        quad_en |=> !quad_en);
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> !tick_en);
    assert_tick_implies_amp_R3: assert property (@(posedge clk) disable iff (rst)
        tick_en |-> amp_en);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] nxt,
    output logic             step
);
    assign nxt  = count + 1'b1;
    assign step = tick && !load && !clear;

    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (load)  count <= load_val;
        else if (clear) count <= '0;
        else if (tick)  count <= nxt;
    end

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> (count == '0));
    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !clear) |=> (count == CNT_W'($past(count) + 1'b1)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !clear) |=> $stable(count));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] nxt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             mask_wr,
    input  logic             mask_val,
    input  logic             ack,
    output logic [CNT_W-1:0] cmp,
    output logic             mask,
    output logic             flag,
    output logic             irq
);
    logic hit;
    assign hit = step && (nxt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp  <= '0;
            mask <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (cmp_wr)  cmp  <= cmp_val;
            if (mask_wr) mask <= mask_val;
            if (hit)      flag <= 1'b1;
            else if (ack) flag <= 1'b0;
        end
    end

    assign irq = flag && !mask;

    assert_match_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (step && (nxt == cmp)) |=> flag);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        (!flag && !step) |=> !flag);
    assert_mask_keeps_R11: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && flag && !ack) |=> flag);
endmodule

// File: rtl/track_timer.sv
module track_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int TICK_LOG2 = 12,
    parameter int AMP_LOG2  = 10,
    parameter int QUAD_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             quad_en,
    output logic             amp_en,
    output logic             tick_en,
    output logic             irq
);
    wr_act_t          act;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cmp;
    logic             step;
    logic             mask;
    logic             flag;

    assign act = decode_wr(wr_en, slot_e'(addr), wr_data[CMD_CLR_BIT], wr_data[CMD_ACK_BIT]);

    tmr_prescaler #(
        .TICK_LOG2(TICK_LOG2), .AMP_LOG2(AMP_LOG2), .QUAD_LOG2(QUAD_LOG2)
    ) u_pre (
        .clk(clk), .rst(rst),
        .quad_en(quad_en), .amp_en(amp_en), .tick_en(tick_en)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_en),
        .load(act.load), .clear(act.clear), .load_val(wr_data),
        .count(count), .nxt(nxt), .step(step)
    );

    tmr_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst(rst), .step(step), .nxt(nxt),
        .cmp_wr(act.cmp_wr), .cmp_val(wr_data),
        .mask_wr(act.mask_wr), .mask_val(wr_data[CTRL_MASK_BIT]),
        .ack(act.ack),
        .cmp(cmp), .mask(mask), .flag(flag), .irq(irq)
    );

    always_comb begin
        case (slot_e'(addr))
            SLOT_COUNT: rd_data = count;
            SLOT_CMP:   rd_data = cmp;
            SLOT_CTRL:  rd_data = {{(CNT_W-2){1'b0}}, flag, mask};
            default:    rd_data = '0;
        endcase
    end

    assert_irq_needs_unmask_R11: assert property (@(posedge clk) disable iff (rst)
        (irq && !act.ack) |=> (flag || mask) && (irq || mask));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_en && (count == {CNT_W{1'b1}})) |=> (count == '0));
endmodule

// File: tb/tb_track_timer.sv
module tb_track_timer;
    localparam int CW = 4;
    localparam int TL = 3;
    localparam int AL = 2;
    localparam int QL = 1;
    localparam int TDIV = 1 << TL;
    localparam int ADIV = 1 << AL;
    localparam int QDIV = 1 << QL;
    localparam int CMOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data, count;
    logic          quad_en, amp_en, tick_en, irq;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;

    track_timer #(.CNT_W(CW), .TICK_LOG2(TL), .AMP_LOG2(AL), .QUAD_LOG2(QL)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .count(count), .quad_en(quad_en), .amp_en(amp_en),
        .tick_en(tick_en), .irq(irq)
    );

    always #10 clk = ~clk;

    // Arithmetic reference of the requirements.
    int m_cyc, m_cnt, m_cmp, m_mask, m_flag;
    int nc;
    bit tk, ld, cl, stp;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc <= 0; m_cnt <= 0; m_cmp <= 0; m_mask <= 0; m_flag <= 0;
        end else begin
            tk = (m_cyc % TDIV) == TDIV - 1;
            ld = wr_en && addr == 2'd0;
            cl = wr_en && addr == 2'd3 && wr_data[0];
            nc = (m_cnt + 1) % CMOD;
            stp = tk && !ld && !cl;
            m_cyc <= m_cyc + 1;
            if (ld) m_cnt <= int'(wr_data);
            else if (cl) m_cnt <= 0;
            else if (tk) m_cnt <= nc;
            if (wr_en && addr == 2'd1) m_cmp <= int'(wr_data);
            if (wr_en && addr == 2'd2) m_mask <= int'(wr_data[0]);
            if (stp && nc == m_cmp) m_flag <= 1;
            else if (wr_en && addr == 2'd3 && wr_data[1]) m_flag <= 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 quad_en", int'(quad_en), int'((m_cyc % QDIV) == QDIV - 1));
            chk("R3 amp_en",  int'(amp_en),  int'((m_cyc % ADIV) == ADIV - 1));
            chk("R4 tick_en", int'(tick_en), int'((m_cyc % TDIV) == TDIV - 1));
            chk("R5/R6/R7 count", int'(count), m_cnt);
            chk("R11 irq", int'(irq), int'(m_flag != 0 && m_mask == 0));
        end
    end

    // Called at a negedge; returns at the following negedge.
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; addr = 2'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        addr = 2'(a);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!tick_en) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1 reset state, R12 readback
        chk("R1 count", int'(count), 0);
        chk("R1 irq", int'(irq), 0);
        rd_chk(0, 0, "R1 R12 slot0");
        rd_chk(1, 0, "R1 R12 slot1");
        rd_chk(2, 0, "R1 R12 slot2");

        // Free run through two wraps (R4, R5); compare 0 matches at wrap (R9)
        repeat (2 * CMOD * TDIV + 5) @(negedge clk);
        rd_chk(2, 2, "R9 flag after wrap");
        wr(3, 2);
        rd_chk(2, 0, "R10 ack clears flag");

        // Sweep every compare value
        for (int v = 0; v < CMOD; v++) begin
            wr(1, v);
            rd_chk(1, v, "R12 compare readback");
            wr(3, 3);
            repeat (CMOD * TDIV + 3) @(negedge clk);
            rd_chk(2, 2, "R9 flag after sweep");
            chk("R11 irq after sweep", int'(irq), 1);
        end
        wr(3, 2);

        // R6 load coinciding with tick
        wait_tick();
        wr(0, 5);
        chk("R6 load beats tick", int'(count), 5);
        rd_chk(0, 5, "R12 count readback");

        // R7 clear coinciding with tick
        wr(0, 9);
        wait_tick();
        wr(3, 1);
        chk("R7 clear beats tick", int'(count), 0);

        // R8 compare write leaves counter alone
        wait_tick();
        wr(0, 7);
        wr(1, 3);
        chk("R8 count unchanged", int'(count), 7);

        // R9 load onto compare value sets nothing
        wr(3, 2);
        wait_tick();
        wr(1, 10);
        wr(0, 10);
        rd_chk(2, 0, "R9 load no match");

        // R10 match wins over ack in same cycle
        wr(1, 12);
        wr(0, 11);
        wait_tick();
        wr(3, 2);
        rd_chk(2, 2, "R10 set beats ack");
        wr(3, 2);

        // R11 mask hides but keeps the match
        wr(2, 1);
        wr(1, 2);
        wr(0, 1);
        repeat (2 * TDIV) @(negedge clk);
        chk("R11 masked irq", int'(irq), 0);
        rd_chk(2, 3, "R11 flag kept under mask");
        wr(2, 0);
        chk("R11 unmasked irq", int'(irq), 1);

        repeat (TDIV) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule